// File: doc/BRIEF.md
# Configuration ROM Header Validator

This block checks the header of a configuration ROM image that arrives one byte per transfer, starting at byte 0. With the first byte it also takes the total image length that the caller expects. While the bytes stream in, it runs two CRC engines at the same time. A CRC-8 covers the 64-bit identifier. A CRC-32C covers the data region, which starts at the revision byte and runs to the end of the image. The block also latches the header bytes it will decode.

One cycle after the last byte it raises `done` for one cycle. In that cycle the identifier, revision, vendor and model fields, the header size that a later entry walker should use, and the status flags are all valid together. The fatal flags are size mismatch and identifier CRC error. The warnings are data CRC mismatch and unknown revision, and they do not affect `hdr_ok`.

The byte input is a valid/ready stream. A byte moves on a rising edge where `in_valid` and `in_ready` are both high. The block stalls its source only during the `done` cycle, when `in_ready` is low. The source must hold the byte and `in_valid` until the byte is accepted. The header layout depends on the revision byte. Revision 3 selects a 16-byte header with no identifier check and no vendor or model fields. Every other revision selects a 22-byte header.

Top module: `cfgrom_hdr_check`

## Requirements
- R1: `in_ready` is high in every cycle except the cycle in which `done` is high. A byte offered while `in_ready` is low is not consumed.
- R2: `done` is high for exactly one cycle, in the cycle after the byte numbered `img_len`-1 is accepted. All result outputs keep their values until the first byte of the next image is accepted.
- R3: `img_len` is sampled together with byte 0. A value of 0 is treated as 1.
- R4: Bytes 14 (low) and 15 (high) hold a little-endian length field. Its low 12 bits are the data length, and its top 4 bits are ignored. `size_err` is high when `img_len` is below 16, or when the data length plus 13 differs from `img_len`.
- R5: The identifier CRC is a CRC-8 over bytes 1 to 8. It uses polynomial 0x07 and seed 0xFF, shifts MSB first, and has no final inversion. It is compared with byte 0. `uid_err` is high only for a long-layout image with no size error whose CRC differs.
- R6: The data CRC is a reflected CRC-32C over byte 13 to the last byte. It uses polynomial 0x82F63B78, an all-ones seed and a final inversion. It is compared with the little-endian word in bytes 9 to 12. `crc_warn` is high only when there is no size error and the CRC differs. It never clears `hdr_ok`.
- R7: Revision byte 13 equal to 3 selects the short layout. In that layout `hdr_size` is 16, the vendor, model, model-revision and ROM-revision outputs are 0, and the identifier CRC is not checked.
- R8: Any other revision selects the long layout. In that layout `hdr_size` is 22, vendor is bytes 16–17, model is bytes 18–19 (both little-endian), model revision is byte 20 and ROM revision is byte 21.
- R9: `rev_warn` is high when the revision byte is neither 1 nor 3.
- R10: `uid` is bytes 1 to 8 with byte 1 least significant. `revision` is byte 13. `hdr_ok` equals not `size_err` and not `uid_err`.
- R11: After reset `done` is low and `in_ready` is high.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| img_len | input | LEN_W | expected total image length, sampled with byte 0 |
| in_valid | input | 1 | byte stream valid |
| in_ready | output | 1 | byte stream ready |
| in_data | input | 8 | stream byte |
| done | output | 1 | one-cycle pulse: results valid |
| hdr_ok | output | 1 | no fatal error |
| size_err | output | 1 | length mismatch (fatal) |
| uid_err | output | 1 | identifier CRC-8 mismatch (fatal) |
| crc_warn | output | 1 | data CRC-32C mismatch (warning) |
| rev_warn | output | 1 | unrecognised revision (warning) |
| hdr_size | output | 5 | header size for the entry walker: 16 or 22 |
| uid | output | 64 | identifier |
| revision | output | 8 | revision byte |
| vendor_id | output | 16 | vendor ID |
| model_id | output | 16 | model ID |
| model_rev | output | 8 | model revision |
| rom_rev | output | 8 | ROM revision |

## Verification
Properties that hold on every cycle are checked by assertions. These are the stall during `done`, the single-cycle width of `done`, the rule that `done` only follows an accepted byte, the stability of the results between accepted bytes, the byte counter staying inside the sampled length, and the rule that short-layout results never carry an identifier error or vendor data. The bench scenarios are needed for the rest. Only they can show that the two CRC values, the field byte positions, the length arithmetic and the handling of lengths 0 and below 16 are correct. They sweep revisions, data lengths, corruptions, gaps in the stream and a byte held during the stall.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned DATA_START  = 13;
  localparam int unsigned LEN_FIELD_W = 12;
  localparam int unsigned HDR_LONG    = 22;
  localparam int unsigned HDR_SHORT   = 16;
  localparam int unsigned UID_FIRST   = 1;
  localparam int unsigned UID_LAST    = 8;
  localparam int unsigned DCRC_FIRST  = 9;
  localparam logic [7:0]  REV_SHORT   = 8'd3;
  localparam logic [7:0]  REV_BASE    = 8'd1;
  localparam logic [7:0]  CRC8_POLY   = 8'h07;
  localparam logic [7:0]  CRC8_SEED   = 8'hFF;
  localparam logic [31:0] CRC32_POLY  = 32'h82F63B78;
  localparam logic [31:0] CRC32_SEED  = 32'hFFFFFFFF;

  typedef enum logic {LAYOUT_LONG = 1'b0, LAYOUT_SHORT = 1'b1} layout_e;

  function automatic logic [7:0] crc8_step(input logic [7:0] s, input logic [7:0] b);
    logic [7:0] v;
    v = s ^ b;
    for (int k = 0; k < 8; k++)
      v = v[7] ? ((v << 1) ^ CRC8_POLY) : (v << 1);
    return v;
  endfunction

  function automatic logic [31:0] crc32c_step(input logic [31:0] s, input logic [7:0] b);
    logic [31:0] v;
    v = s ^ {24'd0, b};
    for (int k = 0; k < 8; k++)
      v = v[0] ? ((v >> 1) ^ CRC32_POLY) : (v >> 1);
    return v;
  endfunction
endpackage

// File: rtl/cfgrom_crc8.sv
module cfgrom_crc8
  import cfgrom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= CRC8_SEED;
    else if (clr) crc <= CRC8_SEED;
    else if (en)  crc <= crc8_step(crc, din);
  end

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/cfgrom_crc32c.sv
module cfgrom_crc32c
  import cfgrom_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  logic [31:0] state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= CRC32_SEED;
    else if (clr) state <= CRC32_SEED;
    else if (en)  state <= crc32c_step(state, din);
  end

  assign crc = ~state;

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/cfgrom_lanes.sv
module cfgrom_lanes #(
  parameter int unsigned NUM_LANES = 22,
  parameter int unsigned IDX_W     = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   first,
  input  logic                   acc,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             din,
  output logic [NUM_LANES*8-1:0] lanes
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= 8'd0;
      else if (first)
        q <= (k == 0) ? din : 8'd0;
      else if (acc && (idx == IDX_W'(k)))
        q <= din;
    end
    assign lanes[k*8 +: 8] = q;
  end
endmodule

// File: rtl/cfgrom_hdr_check.sv
module cfgrom_hdr_check
  import cfgrom_pkg::*;
#(
  parameter int unsigned LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] img_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             done,
  output logic             hdr_ok,
  output logic             size_err,
  output logic             uid_err,
  output logic             crc_warn,
  output logic             rev_warn,
  output logic [4:0]       hdr_size,
  output logic [63:0]      uid,
  output logic [7:0]       revision,
  output logic [15:0]      vendor_id,
  output logic [15:0]      model_id,
  output logic [7:0]       model_rev,
  output logic [7:0]       rom_rev
);
  localparam int unsigned SUM_W = LEN_W + 1;

  logic             busy_q, done_q;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic             acc, first, last;
  logic [LEN_W-1:0] idx, cur_len, len_in;
  logic [HDR_LONG*8-1:0] hdr;
  logic [7:0]       crc8_val;
  logic [31:0]      crc32_val;

  assign in_ready = !done_q;
  assign done     = done_q;
  assign acc      = in_valid && in_ready;
  assign first    = acc && !busy_q;
  assign idx      = busy_q ? cnt_q : '0;
  assign len_in   = (img_len == '0) ? LEN_W'(1) : img_len;
  assign cur_len  = busy_q ? len_q : len_in;
  assign last     = acc && (idx == cur_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= LEN_W'(1);
    end else begin
      done_q <= last;
      if (first) len_q <= len_in;
      if (acc) begin
        busy_q <= !last;
        cnt_q  <= idx + LEN_W'(1);
      end
    end
  end

  cfgrom_lanes #(.NUM_LANES(HDR_LONG), .IDX_W(LEN_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .first(first), .acc(acc),
    .idx(idx), .din(in_data), .lanes(hdr)
  );

  cfgrom_crc8 u_crc8 (
    .clk(clk), .rst_n(rst_n), .clr(first),
    .en(acc && busy_q && (idx >= LEN_W'(UID_FIRST)) && (idx <= LEN_W'(UID_LAST))),
    .din(in_data), .crc(crc8_val)
  );

  cfgrom_crc32c u_crc32 (
    .clk(clk), .rst_n(rst_n), .clr(first),
    .en(acc && busy_q && (idx >= LEN_W'(DATA_START))),
    .din(in_data), .crc(crc32_val)
  );

  layout_e              layout;
  logic [LEN_FIELD_W-1:0] dlen;
  logic [SUM_W-1:0]     total;
  logic [31:0]          stored_dcrc;

  always_comb begin
    revision    = hdr[DATA_START*8 +: 8];
    layout      = (revision == REV_SHORT) ? LAYOUT_SHORT : LAYOUT_LONG;
    dlen        = {hdr[(DATA_START+2)*8 +: 4], hdr[(DATA_START+1)*8 +: 8]};
    total       = SUM_W'(dlen) + SUM_W'(DATA_START);
    stored_dcrc = hdr[DCRC_FIRST*8 +: 32];
    uid         = hdr[UID_FIRST*8 +: 64];

    size_err = (len_q < LEN_W'(HDR_SHORT)) || (total != SUM_W'(len_q));
    rev_warn = (revision != REV_SHORT) && (revision != REV_BASE);
    crc_warn = !size_err && (crc32_val != stored_dcrc);
    uid_err  = !size_err && (layout == LAYOUT_LONG) && (crc8_val != hdr[7:0]);
    hdr_ok   = !size_err && !uid_err;

    if (layout == LAYOUT_SHORT) begin
      hdr_size  = 5'(HDR_SHORT);
      vendor_id = '0;
      model_id  = '0;
      model_rev = '0;
      rom_rev   = '0;
    end else begin
      hdr_size  = 5'(HDR_LONG);
      vendor_id = hdr[16*8 +: 16];
      model_id  = hdr[18*8 +: 16];
      model_rev = hdr[20*8 +: 8];
      rom_rev   = hdr[21*8 +: 8];
    end
  end

  assert_stall_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid && in_ready));
  assert_results_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(uid) && $stable(hdr_size) && $stable(size_err)));
  assert_count_in_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < len_q));
  assert_short_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hdr_size == 5'(HDR_SHORT)) |-> (!uid_err && vendor_id == 16'd0));
  assert_warn_nonfatal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && crc_warn) |-> !size_err);
endmodule

// File: tb/cfgrom_hdr_check_test.sv
module cfgrom_hdr_check_test;
  localparam int LEN_W = 13;

  logic clk = 0, rst_n = 0;
  logic [LEN_W-1:0] img_len = '0;
  logic in_valid = 0, in_ready;
  logic [7:0] in_data = '0;
  logic done, hdr_ok, size_err, uid_err, crc_warn, rev_warn;
  logic [4:0] hdr_size;
  logic [63:0] uid;
  logic [7:0] revision, model_rev, rom_rev;
  logic [15:0] vendor_id, model_id;

  cfgrom_hdr_check #(.LEN_W(LEN_W)) uut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] img [0:127];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc8(input int a, input int b);
    logic [7:0] v = 8'hFF;
    for (int i = a; i <= b; i++) begin
      v ^= img[i];
      for (int k = 0; k < 8; k++) v = v[7] ? ((v << 1) ^ 8'h07) : (v << 1);
    end
    return v;
  endfunction

  function automatic logic [31:0] ref_crc32(input int a, input int b);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = a; i <= b; i++) begin
      c ^= {24'd0, img[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input logic [7:0] rev, input int dlen, input int seed);
    logic [31:0] c;
    int total = dlen + 13;
    for (int i = 0; i < 128; i++) img[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    img[13] = rev;
    img[14] = dlen[7:0];
    img[15] = {4'hA, 4'(dlen >> 8)};
    img[0]  = ref_crc8(1, 8);
    c = ref_crc32(13, total - 1);
    img[9] = c[7:0]; img[10] = c[15:8]; img[11] = c[23:16]; img[12] = c[31:24];
  endtask

  task automatic send(input int nbytes, input int lenval, input bit gaps, input bit drop);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin in_valid = 0; @(negedge clk); end
      in_valid = 1; in_data = img[i];
      if (i == 0) img_len = LEN_W'(lenval);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    if (drop) in_valid = 0;
  endtask

  task automatic expect_res(input int nbytes, input int lenval);
    bit e_size, e_short, e_uid, e_crc, e_rev;
    int dl, eff;
    eff = (lenval == 0) ? 1 : lenval;
    dl = (eff >= 16) ? {img[15][3:0], img[14]} : 0;
    e_short = (eff >= 14) && (img[13] == 8'd3);
    e_size = (eff < 16) || (dl + 13 != eff);
    e_uid = !e_size && !e_short && (ref_crc8(1, 8) != img[0]);
    e_crc = !e_size && (ref_crc32(13, eff - 1) != {img[12], img[11], img[10], img[9]});
    e_rev = (eff >= 14) ? (img[13] != 1 && img[13] != 3) : 1'b1;
    chk(done === 1'b1, "R2 done after last byte", done, 1);
    chk(in_ready === 1'b0, "R1 ready low in done", in_ready, 0);
    chk(size_err === e_size, "R4 size_err", size_err, e_size);
    chk(uid_err === e_uid, "R5 uid_err", uid_err, e_uid);
    chk(crc_warn === e_crc, "R6 crc_warn", crc_warn, e_crc);
    chk(hdr_ok === (!e_size && !e_uid), "R10 hdr_ok", hdr_ok, !e_size && !e_uid);
    if (eff >= 22) begin
      chk(rev_warn === e_rev, "R9 rev_warn", rev_warn, e_rev);
      chk(revision === img[13], "R10 revision", revision, img[13]);
      chk(uid === {img[8], img[7], img[6], img[5], img[4], img[3], img[2], img[1]},
          "R10 uid", uid, {img[8], img[7], img[6], img[5], img[4], img[3], img[2], img[1]});
      if (e_short) begin
        chk(hdr_size === 5'd16, "R7 hdr_size", hdr_size, 16);
        chk({vendor_id, model_id, model_rev, rom_rev} === 48'd0, "R7 fields zero",
            {vendor_id, model_id, model_rev, rom_rev}, 0);
      end else begin
        chk(hdr_size === 5'd22, "R8 hdr_size", hdr_size, 22);
        chk(vendor_id === {img[17], img[16]}, "R8 vendor", vendor_id, {img[17], img[16]});
        chk(model_id === {img[19], img[18]}, "R8 model", model_id, {img[19], img[18]});
        chk({model_rev, rom_rev} === {img[20], img[21]}, "R8 revs",
            {model_rev, rom_rev}, {img[20], img[21]});
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] revs [6] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd255};
    int dls [3] = '{9, 17, 40};
    logic [63:0] hold_uid;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && in_ready === 1'b1, "R11 reset state", {done, in_ready}, 2'b01);
    rst_n = 1;
    for (int r = 0; r < 6; r++)
      for (int d = 0; d < 3; d++)
        for (int m = 0; m < 4; m++) begin
          int total = dls[d] + 13;
          int nb = total, lv = total;
          build(revs[r], dls[d], r * 12 + d * 4 + m);
          if (m == 1) img[0] ^= 8'h01;
          if (m == 2) img[total - 1] ^= 8'h40;
          if (m == 3) begin nb = total + 1; lv = total + 1; end
          send(nb, lv, (m + d) % 2 == 1, m != 0);
          expect_res(nb, lv);
          if (m == 0) begin
            in_valid = 0;
            hold_uid = uid;
            @(negedge clk);
            chk(done === 1'b0, "R2 done one cycle", done, 0);
            chk(in_ready === 1'b1, "R1 ready back", in_ready, 1);
            repeat (3) @(negedge clk);
            chk(uid === hold_uid, "R2 results held", uid, hold_uid);
          end
        end
    build(8'd1, 20, 3);
    send(10, 10, 0, 1);
    expect_res(10, 10);
    chk(size_err === 1'b1, "R4 short image", size_err, 1);
    build(8'd1, 20, 4);
    send(1, 0, 0, 1);
    expect_res(1, 0);
    chk(size_err === 1'b1, "R3 zero length as one byte", size_err, 1);
    build(8'd3, 3, 5);
    send(16, 16, 1, 1);
    expect_res(16, 16);
    chk(hdr_ok === 1'b1 && crc_warn === 1'b0, "R7 minimal short image", {hdr_ok, crc_warn}, 2'b10);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule